// File: doc/BRIEF.md
# SPI Master Shift Engine

This block is the serial core of an SPI master. The host sets the clock divider, clock polarity, clock phase and bit order on its configuration inputs. It then strobes a data word into the engine. The engine raises its busy flag and drives the first bit on the master-out line. It then produces the serial clock from the system clock and moves the rest of the word out. Meanwhile it captures the master-in line into a receive word. When the last serial clock edge has gone by, busy falls, a single-cycle done pulse appears and the received word is presented.

All timing is counted in system-clock cycles. The serial clock period is an even number of system clocks from 8 to 256, with equal high and low halves. The first serial clock edge comes after a lead time that depends on the phase setting. After the transfer the master-out line keeps the final bit until the next accepted write. The word length is a parameter. Chip select, buffering and pad timing are left to the surrounding logic.

Top module: `spi_shift_master`

## Requirements
- R1: While reset is asserted and just after it, busy is 0, done is 0, the master-out line is 0, the received word is 0 and the serial clock equals the polarity input.
- R2: The serial clock half-period H is the divider value limited to the range 8..256, divided by two and rounded down, so the period is 2H system clocks. Every serial clock edge after the first comes exactly H system clocks after the previous one.
- R3: Whenever busy is 0, the serial clock equals the polarity input. During a transfer it starts at the polarity latched at the write and toggles 2×WORD_W times, so it ends at the idle level.
- R4: Count the serial clock edges of a transfer from 0. With phase 0 the master-in line is sampled on the odd edges, and the master-out line changes on the even edges except edge 0. With phase 1 it is sampled on the even edges, and master-out changes on the odd edges except the last one. This gives transmit on rising edges for polarity 0/phase 0 and polarity 1/phase 1, and on falling edges for polarity 0/phase 1 and polarity 1/phase 0. Receive is on the opposite edge.
- R5: The first serial clock edge comes H system clocks after the accepting write when phase is 0, and H+4 system clocks after it when phase is 1.
- R6: When the LSB-first input is 0, bit WORD_W-1 is sent first and the first received bit lands in bit WORD_W-1 of the received word. When it is 1, bit 0 is sent first and the first received bit lands in bit 0.
- R7: After a transfer ends, the master-out line keeps the value of the final bit until the next accepted write.
- R8: A write strobe while busy is 1 is ignored. The running transfer's data, timing and length are unchanged.
- R9: Done is high for exactly one system clock. It rises in the same cycle that busy falls, and the received word changes only in that cycle.
- R10: The cycle after a write strobe is sampled while idle, busy is 1 and the master-out line carries the first bit of the word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_div | input | DIV_W | Serial clock period in system clocks (limited to 8..256, made even) |
| cfg_cpol | input | 1 | Serial clock idle level |
| cfg_cpha | input | 1 | Clock phase select |
| cfg_lsb_first | input | 1 | 1: least significant bit first |
| wr_stb | input | 1 | Data-register write strobe |
| wr_data | input | WORD_W | Word to transmit |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| rx_data | output | WORD_W | Last received word |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Master-out serial data |
| miso | input | 1 | Master-in serial data |

## Verification
The bench builds the engine with its default WORD_W of 8 and DIV_W of 9. Nine divider bits let the bench apply values below the minimum, odd values, 255 and 300. This reaches the lower limit, the rounding down to an even period and the 256 upper cap. With eight bits per word there are sixteen edges per transfer. That is enough to cover both phase rules for the first and last edge, a write strobe landing in the middle of a transfer, and the reversal of both shift paths when the bit order is LSB-first.

// File: rtl/spi_shift_pkg.sv
package spi_shift_pkg;
   localparam int unsigned SPI_MIN_PERIOD  = 8;
   localparam int unsigned SPI_MAX_PERIOD  = 256;
   localparam int unsigned SPI_PHASE_EXTRA = 4;

   // half serial period in system clocks after range limiting
   function automatic int unsigned spi_half(input int unsigned div);
      int unsigned p;
      if (div < SPI_MIN_PERIOD)      p = SPI_MIN_PERIOD;
      else if (div > SPI_MAX_PERIOD) p = SPI_MAX_PERIOD;
      else                           p = div;
      return p >> 1;
   endfunction
endpackage

// File: rtl/spi_edge_timer.sv
module spi_edge_timer #(
   parameter int CNT_W  = 9,
   parameter int EDGES  = 16,
   localparam int EDGE_W = (EDGES > 1) ? $clog2(EDGES) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [CNT_W-1:0]  lead,
   input  logic [CNT_W-1:0]  half,
   output logic              edge_fire,
   output logic [EDGE_W-1:0] edge_idx,
   output logic              last_edge
);
   localparam logic [EDGE_W-1:0] LAST_IDX = EDGE_W'(EDGES - 1);

   logic             run_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] half_q;

   assign edge_fire = run_q && (cnt_q == '0);
   assign last_edge = edge_fire && (edge_idx == LAST_IDX);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q    <= 1'b0;
         cnt_q    <= '0;
         half_q   <= '0;
         edge_idx <= '0;
      end else if (start) begin
         run_q    <= 1'b1;
         cnt_q    <= lead - 1'b1;
         half_q   <= half;
         edge_idx <= '0;
      end else if (run_q) begin
         if (cnt_q == '0) begin
            if (edge_idx == LAST_IDX) begin
               run_q <= 1'b0;
            end else begin
               edge_idx <= edge_idx + 1'b1;
               cnt_q    <= half_q - 1'b1;
            end
         end else begin
            cnt_q <= cnt_q - 1'b1;
         end
      end
   end
endmodule

// File: rtl/spi_tx_shift.sv
module spi_tx_shift #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] data,
   input  logic         lsb_first,
   input  logic         advance,
   output logic         mosi
);
   logic [W-1:0] rev;
   logic [W-1:0] word;
   logic [W-1:0] sh_q;

   for (genvar i = 0; i < W; i++) begin : g_rev
      assign rev[i] = data[W-1-i];
   end

   assign word = lsb_first ? rev : data;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q <= '0;
         mosi <= 1'b0;
      end else if (load) begin
         mosi <= word[W-1];
         sh_q <= {word[W-2:0], 1'b0};
      end else if (advance) begin
         mosi <= sh_q[W-1];
         sh_q <= {sh_q[W-2:0], 1'b0};
      end
   end
endmodule

// File: rtl/spi_rx_shift.sv
module spi_rx_shift #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         sample,
   input  logic         miso,
   input  logic         lsb_first,
   input  logic         commit,
   output logic [W-1:0] rx_word
);
   logic [W-1:0] acc_q;
   logic [W-1:0] acc_nx;
   logic [W-1:0] acc_rev;

   assign acc_nx = sample ? {acc_q[W-2:0], miso} : acc_q;

   for (genvar i = 0; i < W; i++) begin : g_rev
      assign acc_rev[i] = acc_nx[W-1-i];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q   <= '0;
         rx_word <= '0;
      end else begin
         acc_q <= acc_nx;
         if (commit) rx_word <= lsb_first ? acc_rev : acc_nx;
      end
   end
endmodule

// File: rtl/spi_shift_master.sv
module spi_shift_master
   import spi_shift_pkg::*;
#(
   parameter int WORD_W = 8,
   parameter int DIV_W  = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DIV_W-1:0]  cfg_div,
   input  logic              cfg_cpol,
   input  logic              cfg_cpha,
   input  logic              cfg_lsb_first,
   input  logic              wr_stb,
   input  logic [WORD_W-1:0] wr_data,
   output logic              busy,
   output logic              done,
   output logic [WORD_W-1:0] rx_data,
   output logic              sclk,
   output logic              mosi,
   input  logic              miso
);
   localparam int EDGES  = 2 * WORD_W;
   localparam int EDGE_W = $clog2(EDGES);
   localparam logic [EDGE_W-1:0] LAST_IDX = EDGE_W'(EDGES - 1);

   if (WORD_W < 2) begin : g_bad_word
      $error("spi_shift_master: WORD_W must be at least 2");
   end
   if (DIV_W < 9) begin : g_bad_div
      $error("spi_shift_master: DIV_W must reach 256");
   end

   logic              busy_q, done_q, pol_q, pha_q, lsb_q, tog_q;
   logic              accept;
   logic [DIV_W-1:0]  half_now, lead_now;
   logic              edge_fire, last_edge, rx_edge, tx_edge;
   logic [EDGE_W-1:0] edge_idx;

   assign accept   = wr_stb && !busy_q;
   assign half_now = DIV_W'(spi_half(32'(cfg_div)));
   assign lead_now = cfg_cpha ? half_now + DIV_W'(SPI_PHASE_EXTRA) : half_now;

   assign rx_edge = edge_fire && (edge_idx[0] != pha_q);
   assign tx_edge = edge_fire &&
                    (pha_q ? (edge_idx[0] && edge_idx != LAST_IDX)
                           : (!edge_idx[0] && edge_idx != '0));

   spi_edge_timer #(.CNT_W(DIV_W), .EDGES(EDGES)) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (accept),
      .lead      (lead_now),
      .half      (half_now),
      .edge_fire (edge_fire),
      .edge_idx  (edge_idx),
      .last_edge (last_edge)
   );

   spi_tx_shift #(.W(WORD_W)) u_tx (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (accept),
      .data      (wr_data),
      .lsb_first (cfg_lsb_first),
      .advance   (tx_edge),
      .mosi      (mosi)
   );

   spi_rx_shift #(.W(WORD_W)) u_rx (
      .clk       (clk),
      .rst_n     (rst_n),
      .sample    (rx_edge),
      .miso      (miso),
      .lsb_first (lsb_q),
      .commit    (last_edge),
      .rx_word   (rx_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         done_q <= 1'b0;
         pol_q  <= 1'b0;
         pha_q  <= 1'b0;
         lsb_q  <= 1'b0;
         tog_q  <= 1'b0;
      end else begin
         done_q <= last_edge;
         if (accept) begin
            busy_q <= 1'b1;
            pol_q  <= cfg_cpol;
            pha_q  <= cfg_cpha;
            lsb_q  <= cfg_lsb_first;
            tog_q  <= 1'b0;
         end else begin
            if (edge_fire) tog_q  <= ~tog_q;
            if (last_edge) busy_q <= 1'b0;
         end
      end
   end

   assign busy = busy_q;
   assign done = done_q;
   assign sclk = busy_q ? (pol_q ^ tog_q) : cfg_cpol;
endmodule

// File: rtl/spi_shift_master_chk.sv
module spi_shift_master_chk #(
   parameter int WORD_W = 8,
   parameter int DIV_W  = 9
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_cpol,
   input logic              wr_stb,
   input logic              busy,
   input logic              done,
   input logic [WORD_W-1:0] rx_data,
   input logic              sclk,
   input logic              mosi
);
   logic seen_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) seen_q <= 1'b0;
      else        seen_q <= 1'b1;
   end

   p_idle_level_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> sclk == cfg_cpol);

   p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_done_at_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (seen_q && done) |-> (!busy && $past(busy)));

   p_rx_only_on_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (seen_q && !done) |-> $stable(rx_data));

   p_hold_last_bit_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (seen_q && !busy && !$past(busy)) |-> $stable(mosi));

   p_busy_from_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (seen_q && $rose(busy)) |-> $past(wr_stb));
endmodule

bind spi_shift_master spi_shift_master_chk #(.WORD_W(WORD_W), .DIV_W(DIV_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cfg_cpol (cfg_cpol),
   .wr_stb   (wr_stb),
   .busy     (busy),
   .done     (done),
   .rx_data  (rx_data),
   .sclk     (sclk),
   .mosi     (mosi)
);

// File: tb/sim_spi_shift_master.sv
`timescale 1ns/1ps
module sim_spi_shift_master;
   localparam int W  = 8;
   localparam int DW = 9;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [DW-1:0] cfg_div = DW'(8);
   logic          cfg_cpol = 1'b1;
   logic          cfg_cpha = 1'b0;
   logic          cfg_lsb_first = 1'b0;
   logic          wr_stb = 1'b0;
   logic [W-1:0]  wr_data = '0;
   logic          busy, done, sclk, mosi;
   logic [W-1:0]  rx_data;
   logic          miso = 1'b0;

   always #10 clk = ~clk;

   spi_shift_master #(.WORD_W(W), .DIV_W(DW)) u0 (
      .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div), .cfg_cpol(cfg_cpol),
      .cfg_cpha(cfg_cpha), .cfg_lsb_first(cfg_lsb_first), .wr_stb(wr_stb),
      .wr_data(wr_data), .busy(busy), .done(done), .rx_data(rx_data),
      .sclk(sclk), .mosi(mosi), .miso(miso)
   );

   int n_chk = 0, n_fail = 0, cyc = 0;
   bit finished = 1'b0;

   task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h (cycle %0d)", req, what, act, exp, cyc);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   bit m_busy, m_done, m_tog, m_pol, m_pha, m_lsb, m_mosi;
   logic [W-1:0] m_word, m_rx;
   int m_k, m_h, m_l, m_b, m_r;
   bit rbits[W];

   function automatic int clamp_half(int d);
      int p;
      p = (d < 8) ? 8 : ((d > 256) ? 256 : d);
      return p / 2;
   endfunction

   function automatic bit tx_bit(logic [W-1:0] w, bit lsb, int n);
      return lsb ? w[n] : w[W-1-n];
   endfunction

   always @(posedge clk) begin
      cyc++;
      if (!rst_n) begin
         m_busy = 0; m_done = 0; m_tog = 0; m_mosi = 0; m_rx = '0;
      end else begin
         m_done = 0;
         if (!m_busy) begin
            if (wr_stb) begin
               m_pol = cfg_cpol; m_pha = cfg_cpha; m_lsb = cfg_lsb_first;
               m_word = wr_data;
               m_h = clamp_half(int'(cfg_div));
               m_l = m_pha ? m_h + 4 : m_h;
               m_k = 0; m_b = 1; m_r = 0; m_tog = 0; m_busy = 1;
               m_mosi = tx_bit(m_word, m_lsb, 0);
            end
         end else begin
            m_k++;
            if (m_k >= m_l && ((m_k - m_l) % m_h) == 0) begin
               int e;
               e = (m_k - m_l) / m_h;
               m_tog = ~m_tog;
               if ((e % 2) == (m_pha ? 0 : 1)) begin
                  rbits[m_r] = miso; m_r++;
               end
               if (m_pha ? ((e % 2) == 1 && e < 2*W-1) : ((e % 2) == 0 && e > 0)) begin
                  m_mosi = tx_bit(m_word, m_lsb, m_b); m_b++;
               end
               if (e == 2*W-1) begin
                  m_busy = 0; m_done = 1;
                  for (int i = 0; i < W; i++) m_rx[m_lsb ? i : W-1-i] = rbits[i];
               end
            end
         end
      end
   end

   // ---------------- per-cycle comparison and edge timing ----------------
   int exp_half, exp_lead;
   bit prev_busy = 0, prev_sclk = 0, first_pending = 0;
   int acc_cyc, last_chg;
   logic [15:0] lfsr = 16'hACE1;

   always @(negedge clk) begin
      if (rst_n && cyc > 0) begin
         chk("R10", "busy", busy, m_busy);
         chk("R9",  "done", done, m_done);
         chk(m_busy ? "R4" : "R3", "sclk", sclk, m_busy ? (m_pol ^ m_tog) : cfg_cpol);
         chk(m_busy ? "R6" : "R7", "mosi", mosi, m_mosi);
         chk("R6", "rx_data", rx_data, m_rx);
         if (busy && !prev_busy) begin
            acc_cyc = cyc; first_pending = 1;
         end
         if ((busy || done) && sclk != prev_sclk) begin
            if (first_pending) begin
               chk("R5", "first edge lead", cyc - acc_cyc, exp_lead);
               first_pending = 0;
            end else begin
               chk("R2", "edge spacing", cyc - last_chg, exp_half);
            end
            last_chg = cyc;
         end
         prev_busy = busy; prev_sclk = sclk;
      end
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      miso = lfsr[0];
   end

   // ---------------- stimulus ----------------
   task automatic xfer(int d, bit p, bit h, bit l, logic [W-1:0] w, bit poke);
      @(posedge clk); #5;
      cfg_div = DW'(d); cfg_cpol = p; cfg_cpha = h; cfg_lsb_first = l;
      exp_half = clamp_half(d);
      exp_lead = h ? exp_half + 4 : exp_half;
      wr_stb = 1; wr_data = w;
      @(posedge clk); #5;
      wr_stb = 0;
      if (poke) begin
         repeat (40) @(posedge clk);
         #5; wr_stb = 1; wr_data = ~w;
         @(posedge clk); #5; wr_stb = 0;
      end
      while (busy) begin
         @(posedge clk); #5;
      end
      repeat (3) @(posedge clk);
   endtask

   initial begin
      int busy_cnt;
      repeat (3) @(posedge clk);
      #15;
      // R1: reset state (polarity input high during reset)
      chk("R1", "busy in reset", busy, 0);
      chk("R1", "done in reset", done, 0);
      chk("R1", "mosi in reset", mosi, 0);
      chk("R1", "rx in reset", rx_data, 0);
      chk("R1", "sclk in reset", sclk, 1);
      @(posedge clk); #5; rst_n = 1;
      @(negedge clk);
      chk("R1", "busy after reset", busy, 0);
      chk("R1", "mosi after reset", mosi, 0);

      // R4: the four modes, MSB first
      xfer(8,   0, 0, 0, 8'hA5, 0);
      xfer(8,   0, 1, 0, 8'h3C, 0);
      xfer(8,   1, 0, 0, 8'h96, 0);
      xfer(8,   1, 1, 0, 8'h5A, 0);
      // R6: LSB first in two modes
      xfer(8,   0, 0, 1, 8'hC1, 0);
      @(negedge clk);
      chk("R7", "held final bit after LSB-first", mosi, 1);
      xfer(14,  1, 1, 1, 8'h0F, 0);
      // R2: divider limits and rounding
      xfer(4,   0, 1, 0, 8'hE7, 0);
      xfer(11,  1, 0, 1, 8'h42, 0);
      xfer(255, 0, 0, 0, 8'h18, 0);
      xfer(300, 1, 1, 0, 8'hDB, 0);

      // R3: idle level follows the polarity input
      @(posedge clk); #5; cfg_cpol = 0;
      @(negedge clk); chk("R3", "idle sclk low", sclk, 0);
      @(posedge clk); #5; cfg_cpol = 1;
      @(negedge clk); chk("R3", "idle sclk high", sclk, 1);

      // R8: a strobe in mid-transfer is ignored
      busy_cnt = 0;
      fork
         xfer(12, 0, 1, 0, 8'h81, 1);
         begin
            @(posedge busy);
            while (busy) begin
               @(negedge clk);
               if (busy) busy_cnt++;
            end
         end
      join
      chk("R8", "transfer length with ignored write", busy_cnt, (6 + 4) + (2*W - 1) * 6);
      repeat (20) @(posedge clk);
      @(negedge clk);
      chk("R7", "final bit held while idle", mosi, 1);
      chk("R8", "received word unchanged after idle", rx_data, m_rx);

      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   always @(posedge clk) begin
      if (cyc > 150000 && !finished) begin
         finished = 1;
         n_chk++; n_fail++;
         $display("FAIL watchdog: run did not complete, actual=hung expected=finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule